// File: doc/BRIEF.md
# Multi-Output PWM Edge Generator

This block drives a set of synchronous PWM outputs, by default six (four bridge legs and two synchronous-rectifier drives), from a single period counter. Each output has a programmed rising-edge count and falling-edge count. One count is one timing step of the counter clock, for example 5 ns. The control loop supplies a modulation value once per switching period. Per-edge enable bits choose which edges that value moves. The value is clamped between a high limit and a low limit, both given as fractions of the period. When pulse skipping is enabled, a request below the low limit blanks every output for a whole period. In full-bridge mode each modulated edge moves by half the clamped value, so the modulation is shared between two outputs.

All timing settings are written to a pending bank: period, edges, edge enables, limits, full-bridge and skip modes. An apply strobe copies the whole bank into the active bank at the next period boundary. A switching cycle therefore never mixes old and new timing. The per-output disable bits are not banked. Each one forces its output low from the next clock.

Top module: `pwm_edge_gen`

## Requirements
- R1: After reset every output and `at_limit` are low and the active period is 0, so no edge occurs. With an active period P ≥ 2 the internal count runs 0,1,…,P-1 and then restarts at 0. The cycle in which the count is P-1 is the period boundary.
- R2: An output goes high one clock after the count equals its effective rising edge. It goes low one clock after the count equals its effective falling edge, and the falling edge wins when both are equal. In steady state an output is high for f-r cycles per period when r<f, for P-(r-f) when r>f, and for 0 when r=f.
- R3: An effective edge value at or above P never occurs. A rise that never occurs gives 0 high cycles. A fall that never occurs with a valid rise gives P high cycles.
- R4: Changes on the pending inputs have no effect until `apply` is seen high. The active bank loads at the boundary cycle in or after that pulse, so outputs in the rest of the current period keep the old timing.
- R5: A set bit in `mod_rise_en[i]` or `mod_fall_en[i]` adds the period's modulation shift to that output's rising or falling edge. A clear bit leaves that edge unmoved.
- R6: The high limit is floor(P·hi_pct/128) and the low limit is floor(P·lo_pct/128). `mod_in` is sampled in the boundary cycle. A value above the high limit is replaced by it, and a value below the low limit is replaced by the low limit when skipping is off. The result holds for the whole next period.
- R7: With `skip_en` active, a sampled `mod_in` below the low limit forces all outputs low for the whole next period.
- R8: With `fb_mode` active the shift applied to each enabled edge is the clamped value divided by two, rounded down.
- R9: A set `out_dis[i]` drives output i low from the next clock and does not alter any other output.
- R10: `at_limit` is updated at each boundary. It is high for the next period when the sampled `mod_in` is ≥ the high limit or ≤ the low limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one timing step per cycle |
| rst | input | 1 | Synchronous reset, active high |
| per_set | input | CNT_W | Pending period length in counts |
| rise_set | input | N_OUT×CNT_W | Pending rising-edge counts, one per output |
| fall_set | input | N_OUT×CNT_W | Pending falling-edge counts, one per output |
| mod_rise_en | input | N_OUT | Pending: modulate rising edge of output i |
| mod_fall_en | input | N_OUT | Pending: modulate falling edge of output i |
| fb_mode | input | 1 | Pending: halve the shift (full-bridge sharing) |
| skip_en | input | 1 | Pending: skip pulses below the low limit |
| hi_pct | input | PCT_W | Pending high limit, fraction of period in 1/128 |
| lo_pct | input | PCT_W | Pending low limit, fraction of period in 1/128 |
| apply | input | 1 | Strobe: load pending bank at next boundary |
| mod_in | input | CNT_W | Modulation request from the control loop |
| out_dis | input | N_OUT | Per-output force-low, immediate |
| pwm_out | output | N_OUT | PWM outputs |
| at_limit | output | 1 | Modulation sat at a limit this period |

## Verification
Each output is registered, so it changes one clock after the count reaches an edge. Pending settings and `mod_in` act only from the first count of the period that follows the boundary. The bench therefore waits three full periods after each apply and then counts high cycles over one period, sampling on falling clock edges, and compares them with the closed-form widths of R2 and R3. The boundary test locks onto a one-cycle marker pulse on a spare output. From that point the old width is due for the rest of the current period and the new width in the next one. Disable is checked from the first sample after the clock that follows the change.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int DEF_N_OUT = 6;
    localparam int DEF_CNT_W = 8;
    localparam int DEF_PCT_W = 7;

    typedef enum logic [1:0] {
        CL_MID  = 2'd0,
        CL_HI   = 2'd1,
        CL_LO   = 2'd2,
        CL_SKIP = 2'd3
    } clamp_e;
endpackage

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
    parameter int N_OUT = pwm_pkg::DEF_N_OUT,
    parameter int CNT_W = pwm_pkg::DEF_CNT_W,
    parameter int PCT_W = pwm_pkg::DEF_PCT_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        boundary,
    input  logic                        apply,
    input  logic [CNT_W-1:0]            per_set,
    input  logic [N_OUT-1:0][CNT_W-1:0] rise_set,
    input  logic [N_OUT-1:0][CNT_W-1:0] fall_set,
    input  logic [N_OUT-1:0]            mod_rise_en,
    input  logic [N_OUT-1:0]            mod_fall_en,
    input  logic                        fb_mode,
    input  logic                        skip_en,
    input  logic [PCT_W-1:0]            hi_pct,
    input  logic [PCT_W-1:0]            lo_pct,
    output logic [CNT_W-1:0]            per_act,
    output logic [N_OUT-1:0][CNT_W-1:0] rise_act,
    output logic [N_OUT-1:0][CNT_W-1:0] fall_act,
    output logic [N_OUT-1:0]            mre_act,
    output logic [N_OUT-1:0]            mfe_act,
    output logic                        fb_act,
    output logic                        skip_act,
    output logic [PCT_W-1:0]            hi_act,
    output logic [PCT_W-1:0]            lo_act
);
    typedef struct packed {
        logic [CNT_W-1:0]            per;
        logic [N_OUT-1:0][CNT_W-1:0] rise;
        logic [N_OUT-1:0][CNT_W-1:0] fall;
        logic [N_OUT-1:0]            mre;
        logic [N_OUT-1:0]            mfe;
        logic                        fb;
        logic                        skip;
        logic [PCT_W-1:0]            hi;
        logic [PCT_W-1:0]            lo;
    } bank_t;

    typedef struct packed {
        logic  pend;
        bank_t bank;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (boundary && (st_q.pend || apply)) begin
            st_d.pend      = 1'b0;
            st_d.bank.per  = per_set;
            st_d.bank.rise = rise_set;
            st_d.bank.fall = fall_set;
            st_d.bank.mre  = mod_rise_en;
            st_d.bank.mfe  = mod_fall_en;
            st_d.bank.fb   = fb_mode;
            st_d.bank.skip = skip_en;
            st_d.bank.hi   = hi_pct;
            st_d.bank.lo   = lo_pct;
        end else if (apply) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign per_act  = st_q.bank.per;
    assign rise_act = st_q.bank.rise;
    assign fall_act = st_q.bank.fall;
    assign mre_act  = st_q.bank.mre;
    assign mfe_act  = st_q.bank.mfe;
    assign fb_act   = st_q.bank.fb;
    assign skip_act = st_q.bank.skip;
    assign hi_act   = st_q.bank.hi;
    assign lo_act   = st_q.bank.lo;

    // R4: the active bank moves only across a period boundary
    p_hold_off_boundary_r4: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable(st_q.bank));

    // R4: a pending or same-cycle apply loads the pending period at the boundary
    p_load_at_boundary_r4: assert property (@(posedge clk) disable iff (rst)
        (boundary && (st_q.pend || apply)) |=> (per_act == $past(per_set)));
endmodule

// File: rtl/pwm_mod_clamp.sv
module pwm_mod_clamp #(
    parameter int CNT_W = pwm_pkg::DEF_CNT_W,
    parameter int PCT_W = pwm_pkg::DEF_PCT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             boundary,
    input  logic [CNT_W-1:0] per,
    input  logic [PCT_W-1:0] hi_pct,
    input  logic [PCT_W-1:0] lo_pct,
    input  logic             skip_en,
    input  logic             fb,
    input  logic [CNT_W-1:0] mod_in,
    output logic [CNT_W-1:0] shift,
    output logic             skip,
    output logic             at_limit
);
    import pwm_pkg::*;

    localparam int PROD_W = CNT_W + PCT_W;

    typedef struct packed {
        logic [CNT_W-1:0] shift;
        clamp_e           mode;
        logic             at_lim;
    } state_t;

    state_t st_d, st_q;

    logic [PROD_W-1:0] hi_prod, lo_prod;
    logic [CNT_W-1:0]  hi_c, lo_c, eff;
    clamp_e            mode_c;

    always_comb begin
        hi_prod = PROD_W'(per) * PROD_W'(hi_pct);
        lo_prod = PROD_W'(per) * PROD_W'(lo_pct);
        hi_c    = CNT_W'(hi_prod >> PCT_W);
        lo_c    = CNT_W'(lo_prod >> PCT_W);

        if (mod_in > hi_c) begin
            eff    = hi_c;
            mode_c = CL_HI;
        end else if (mod_in < lo_c) begin
            eff    = lo_c;
            mode_c = skip_en ? CL_SKIP : CL_LO;
        end else begin
            eff    = mod_in;
            mode_c = CL_MID;
        end

        st_d = st_q;
        if (boundary) begin
            st_d.shift  = fb ? (eff >> 1) : eff;
            st_d.mode   = mode_c;
            st_d.at_lim = (mod_in >= hi_c) || (mod_in <= lo_c);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{shift: '0, mode: CL_MID, at_lim: 1'b0};
        else     st_q <= st_d;
    end

    assign shift    = st_q.shift;
    assign skip     = (st_q.mode == CL_SKIP);
    assign at_limit = st_q.at_lim;

    // R6: an over-range request becomes exactly the high limit
    p_high_clamp_r6: assert property (@(posedge clk) disable iff (rst)
        (boundary && (mod_in > hi_c) && !fb) |=> (shift == $past(hi_c)));

    // R10: a request at or beyond either limit raises the flag for the next period
    p_limit_flag_r10: assert property (@(posedge clk) disable iff (rst)
        (boundary && ((mod_in >= hi_c) || (mod_in <= lo_c))) |=> at_limit);

    // R7: a skipped period is always also a limited one
    p_skip_implies_limit_r7: assert property (@(posedge clk) disable iff (rst)
        skip |-> at_limit);

    // R6: outside a boundary the period's shift is held
    p_shift_held_r6: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable(shift));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
    parameter int CNT_W = pwm_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] per,
    input  logic [CNT_W-1:0] rise,
    input  logic [CNT_W-1:0] fall,
    input  logic             mod_rise,
    input  logic             mod_fall,
    input  logic [CNT_W-1:0] shift,
    input  logic             skip,
    input  logic             dis,
    output logic             pwm
);
    localparam int EW = CNT_W + 1;

    typedef struct packed {
        logic out;
    } state_t;

    state_t st_d, st_q;

    logic [EW-1:0] r_eff, f_eff, per_x, cnt_x;
    logic          rise_hit, fall_hit;

    always_comb begin
        per_x    = {1'b0, per};
        cnt_x    = {1'b0, cnt};
        r_eff    = {1'b0, rise} + (mod_rise ? {1'b0, shift} : '0);
        f_eff    = {1'b0, fall} + (mod_fall ? {1'b0, shift} : '0);
        rise_hit = (r_eff < per_x) && (r_eff == cnt_x);
        fall_hit = (f_eff < per_x) && (f_eff == cnt_x);

        st_d = st_q;
        if (dis || skip)   st_d.out = 1'b0;
        else if (fall_hit) st_d.out = 1'b0;
        else if (rise_hit) st_d.out = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pwm = st_q.out;

    // R9: disable forces the pin low on the following clock
    p_disable_low_r9: assert property (@(posedge clk) disable iff (rst)
        dis |=> !pwm);

    // R7: a skipped period keeps the pin low
    p_skip_low_r7: assert property (@(posedge clk) disable iff (rst)
        skip |=> !pwm);

    // R2: a falling-edge match always leaves the pin low
    p_fall_wins_r2: assert property (@(posedge clk) disable iff (rst)
        fall_hit |=> !pwm);

    // R3: the pin can only rise where a rising edge lies inside the period
    p_rise_needs_hit_r3: assert property (@(posedge clk) disable iff (rst)
        (!pwm && !rise_hit) |=> !pwm);
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen #(
    parameter int N_OUT = pwm_pkg::DEF_N_OUT,
    parameter int CNT_W = pwm_pkg::DEF_CNT_W,
    parameter int PCT_W = pwm_pkg::DEF_PCT_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [CNT_W-1:0]            per_set,
    input  logic [N_OUT-1:0][CNT_W-1:0] rise_set,
    input  logic [N_OUT-1:0][CNT_W-1:0] fall_set,
    input  logic [N_OUT-1:0]            mod_rise_en,
    input  logic [N_OUT-1:0]            mod_fall_en,
    input  logic                        fb_mode,
    input  logic                        skip_en,
    input  logic [PCT_W-1:0]            hi_pct,
    input  logic [PCT_W-1:0]            lo_pct,
    input  logic                        apply,
    input  logic [CNT_W-1:0]            mod_in,
    input  logic [N_OUT-1:0]            out_dis,
    output logic [N_OUT-1:0]            pwm_out,
    output logic                        at_limit
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    logic [CNT_W-1:0]            per_act;
    logic [N_OUT-1:0][CNT_W-1:0] rise_act, fall_act;
    logic [N_OUT-1:0]            mre_act, mfe_act;
    logic                        fb_act, skip_act;
    logic [PCT_W-1:0]            hi_act, lo_act;
    logic [CNT_W-1:0]            shift;
    logic                        skip;
    logic                        boundary;

    always_comb begin
        boundary = (per_act <= CNT_W'(1)) || (st_q.cnt == per_act - CNT_W'(1));
        st_d     = st_q;
        st_d.cnt = boundary ? '0 : st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    pwm_shadow #(.N_OUT(N_OUT), .CNT_W(CNT_W), .PCT_W(PCT_W)) u_shadow (
        .clk(clk), .rst(rst), .boundary(boundary), .apply(apply),
        .per_set(per_set), .rise_set(rise_set), .fall_set(fall_set),
        .mod_rise_en(mod_rise_en), .mod_fall_en(mod_fall_en),
        .fb_mode(fb_mode), .skip_en(skip_en), .hi_pct(hi_pct), .lo_pct(lo_pct),
        .per_act(per_act), .rise_act(rise_act), .fall_act(fall_act),
        .mre_act(mre_act), .mfe_act(mfe_act), .fb_act(fb_act),
        .skip_act(skip_act), .hi_act(hi_act), .lo_act(lo_act)
    );

    pwm_mod_clamp #(.CNT_W(CNT_W), .PCT_W(PCT_W)) u_clamp (
        .clk(clk), .rst(rst), .boundary(boundary), .per(per_act),
        .hi_pct(hi_act), .lo_pct(lo_act), .skip_en(skip_act), .fb(fb_act),
        .mod_in(mod_in), .shift(shift), .skip(skip), .at_limit(at_limit)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_chan
        pwm_chan #(.CNT_W(CNT_W)) u_chan (
            .clk(clk), .rst(rst), .cnt(st_q.cnt), .per(per_act),
            .rise(rise_act[i]), .fall(fall_act[i]),
            .mod_rise(mre_act[i]), .mod_fall(mfe_act[i]),
            .shift(shift), .skip(skip), .dis(out_dis[i]), .pwm(pwm_out[i])
        );
    end

    // R1: the count stays inside the active period
    p_count_range_r1: assert property (@(posedge clk) disable iff (rst)
        (per_act != '0) |-> (st_q.cnt < per_act));

    // R1: the count restarts at zero after every boundary
    p_count_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        boundary |=> (st_q.cnt == '0));
endmodule

// File: tb/tb_pwm_edge_gen.sv
module tb_pwm_edge_gen;
    localparam int N = 6;
    localparam int W = 8;
    localparam int PW = 7;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [W-1:0]     per_set = '0;
    logic [N-1:0][W-1:0] rise_set = '0;
    logic [N-1:0][W-1:0] fall_set = '0;
    logic [N-1:0]     mod_rise_en = '0;
    logic [N-1:0]     mod_fall_en = '0;
    logic             fb_mode = 1'b0;
    logic             skip_en = 1'b0;
    logic [PW-1:0]    hi_pct = '0;
    logic [PW-1:0]    lo_pct = '0;
    logic             apply = 1'b0;
    logic [W-1:0]     mod_in = '0;
    logic [N-1:0]     out_dis = '0;
    logic [N-1:0]     pwm_out;
    logic             at_limit;

    int n_checks = 0;
    int n_errors = 0;
    int hc [N];
    int P;

    pwm_edge_gen #(.N_OUT(N), .CNT_W(W), .PCT_W(PW)) dut (
        .clk(clk), .rst(rst), .per_set(per_set), .rise_set(rise_set),
        .fall_set(fall_set), .mod_rise_en(mod_rise_en), .mod_fall_en(mod_fall_en),
        .fb_mode(fb_mode), .skip_en(skip_en), .hi_pct(hi_pct), .lo_pct(lo_pct),
        .apply(apply), .mod_in(mod_in), .out_dis(out_dis),
        .pwm_out(pwm_out), .at_limit(at_limit)
    );

    always #5 clk = ~clk;

    initial begin
        #1500000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // steady-state high cycles per period (R2, R3); -1 when state is history-dependent
    function automatic int exp_hi(input int r, input int f, input int p);
        if (r >= p && f >= p) return -1;
        if (r >= p) return 0;
        if (f >= p) return p;
        if (r < f) return f - r;
        if (r == f) return 0;
        return p - (r - f);
    endfunction

    task automatic do_apply();
        @(negedge clk) apply = 1'b1;
        @(negedge clk) apply = 1'b0;
        repeat (3 * P + 2) @(negedge clk);
    endtask

    task automatic measure();
        for (int i = 0; i < N; i++) hc[i] = 0;
        repeat (P) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) if (pwm_out[i]) hc[i]++;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset pwm_out", int'(pwm_out), 0);
        check("R1 reset at_limit", int'(at_limit), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check("R1 zero period keeps outputs low", int'(pwm_out), 0);

        // edge sweep on output 0
        P = 12;
        per_set = W'(P);
        hi_pct = 7'd127;
        lo_pct = 7'd0;
        rise_set[1] = 8'd2;  fall_set[1] = 8'd9;
        rise_set[5] = 8'd0;  fall_set[5] = 8'd1;
        for (int r = 0; r < 14; r++) begin
            for (int f = 0; f < 14; f++) begin
                rise_set[0] = W'(r);
                fall_set[0] = W'(f);
                do_apply();
                measure();
                if (exp_hi(r, f, P) >= 0)
                    check((r >= P || f >= P) ? "R3 edge outside period" : "R2 edge window",
                          hc[0], exp_hi(r, f, P));
            end
        end
        check("R2 fixed output 1", hc[1], 7);
        check("R2 fixed output 5", hc[5], 1);

        // R4: pending change without apply is ignored
        rise_set[1] = 8'd5;
        repeat (3 * P) @(negedge clk);
        measure();
        check("R4 no apply no effect", hc[1], 7);

        // R4: load lands exactly at the boundary
        P = 16;
        per_set = W'(P);
        rise_set[0] = 8'd4; fall_set[0] = 8'd8;
        rise_set[1] = 8'd2; fall_set[1] = 8'd9;
        do_apply();
        begin
            int guard = 0;
            while (!pwm_out[5] && guard < 100) begin
                @(negedge clk);
                guard++;
            end
        end
        fall_set[0] = 8'd12;
        apply = 1'b1;
        @(negedge clk);
        apply = 1'b0;
        begin
            int old_hi = 0;
            int new_hi = 0;
            for (int k = 2; k < 16; k++) begin
                if (pwm_out[0]) old_hi++;
                @(negedge clk);
            end
            for (int k = 0; k < 16; k++) begin
                if (pwm_out[0]) new_hi++;
                @(negedge clk);
            end
            check("R4 rest of period keeps old timing", old_hi, 4);
            check("R4 next period uses new timing", new_hi, 8);
        end

        // modulation, clamping, skipping, full-bridge
        hi_pct = 7'd64;   // high limit 8 at P=16
        lo_pct = 7'd16;   // low limit 2 at P=16
        rise_set[0] = 8'd1;  fall_set[0] = 8'd5;
        rise_set[1] = 8'd2;  fall_set[1] = 8'd12; mod_rise_en[1] = 1'b1;
        rise_set[2] = 8'd3;  fall_set[2] = 8'd6;  mod_fall_en[2] = 1'b1;
        rise_set[3] = 8'd4;  fall_set[3] = 8'd8;  mod_rise_en[3] = 1'b1; mod_fall_en[3] = 1'b1;
        rise_set[4] = 8'd14; fall_set[4] = 8'd3;  mod_rise_en[4] = 1'b1;
        for (int fb = 0; fb < 2; fb++) begin
            for (int sk = 0; sk < 2; sk++) begin
                for (int m = 0; m < 7; m++) begin
                    int mv;
                    int eff;
                    int sh;
                    bit skipped;
                    string tag;
                    case (m)
                        0: mv = 0;
                        1: mv = 1;
                        2: mv = 2;
                        3: mv = 5;
                        4: mv = 8;
                        5: mv = 9;
                        default: mv = 30;
                    endcase
                    fb_mode = fb[0];
                    skip_en = sk[0];
                    mod_in = W'(mv);
                    do_apply();
                    measure();
                    eff = (mv > 8) ? 8 : (mv < 2) ? 2 : mv;
                    skipped = (sk == 1) && (mv < 2);
                    sh = (fb == 1) ? eff / 2 : eff;
                    tag = skipped ? "R7 pulse skip" : (fb == 1) ? "R8 half shift" :
                          (mv > 8 || mv < 2) ? "R6 clamped shift" : "R5 edge shift";
                    check(tag, hc[0], skipped ? 0 : exp_hi(1, 5, P));
                    check(tag, hc[1], skipped ? 0 : exp_hi(2 + sh, 12, P));
                    check(tag, hc[2], skipped ? 0 : exp_hi(3, 6 + sh, P));
                    check(tag, hc[3], skipped ? 0 : exp_hi(4 + sh, 8 + sh, P));
                    check(tag, hc[4], skipped ? 0 : exp_hi(14 + sh, 3, P));
                    check("R10 at_limit", int'(at_limit), (mv >= 8 || mv <= 2) ? 1 : 0);
                end
            end
        end

        // R9: disable one output; others keep their widths
        fb_mode = 1'b0;
        skip_en = 1'b0;
        mod_in = 8'd4;
        do_apply();
        @(negedge clk) out_dis[1] = 1'b1;
        @(negedge clk);
        measure();
        check("R9 disabled output low", hc[1], 0);
        check("R9 other output unaffected", hc[0], 4);
        check("R9 other output unaffected", hc[3], 4);
        out_dis[1] = 1'b0;
        repeat (3 * P) @(negedge clk);
        measure();
        check("R9 output returns after enable", hc[1], exp_hi(6, 12, P));

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule